// File: doc/BRIEF.md
# Staged-Register Memory Controller

This block is a word-addressed random-access store that a processor can only reach through two holding registers. One holds the address and the other holds the data. The processor loads these registers on idle cycles. It then issues a single command with a start strobe, where the command is either read-a-cell or write-a-cell. The controller runs a fixed sequence. First it decodes the held address. Then it moves one whole cell: into the data register on a read, or out of it on a write. A one-cycle completion pulse ends the sequence.

Both holding registers can always be read back at the ports, and they keep their values across operations. The cell width and the address width are parameters. With an address width of N, the store has 2^N cells.

Top module: `staged_ram_ctrl`

## Requirements
- R1: While reset is low, and after it is released, the address register and data register read 0, and busy and done are 0. Reset does not initialise the cell contents.
- R2: Asserting addr_ld or data_ld on an idle cycle loads addr_d or data_d into its register. The new value is visible on addr_q or data_q after the next clock edge. Loads asserted while busy is high are ignored.
- R3: A start sampled while idle is accepted, and busy is high from the next cycle until the done cycle inclusive. A start sampled while busy is high is ignored and does not cause a second done.
- R4: Every operation has the same latency, whatever its address and direction. Done is high for exactly one cycle, and that cycle begins at the second clock edge after the edge that accepted start. In the cycle after done, busy and done are both 0.
- R5: A read (store=0 at accept) places the addressed cell in data_q, valid in the done cycle. A read leaves the cell unchanged, so a repeated read returns the same value.
- R6: A write (store=1 at accept) copies the data register into the addressed cell. It changes no other cell and leaves the data register unchanged.
- R7: After an operation completes, the address register and data register keep their values. They are not cleared by completion.
- R8: Each access moves a whole CELL_W-bit cell. Every address from 0 to 2^ADDR_W-1 is reachable, including both ends of the range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_ld | input | 1 | Load the address register from addr_d (idle only) |
| addr_d | input | ADDR_W | Address value to load |
| data_ld | input | 1 | Load the data register from data_d (idle only) |
| data_d | input | CELL_W | Data value to load |
| start | input | 1 | Start strobe for one operation |
| store | input | 1 | Direction, sampled with start: 1 write, 0 read |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| addr_q | output | ADDR_W | Current address register |
| data_q | output | CELL_W | Current data register |

## Verification
The main sequence is driven from a table that writes to the lowest address, the highest address and a pair of adjacent addresses. The written values are all-ones, all-zeros and mixed patterns, so that a dropped bit, a wrong row or a lost boundary address shows up on readback. Each read is issued with a different value preloaded into the data register, which separates a real transfer from a stale register. Rewriting one address and then reading its neighbour separates a correctly decoded write from one that spills onto the adjacent row. Repeated reads show that reads are non-destructive. Directed cases hold start and both load strobes during a busy window to show they are ignored, and a reset is asserted in the middle of an operation.

// File: rtl/staged_ram_ctrl.sv
module staged_ram_ctrl #(
  parameter int CELL_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_ld,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic              data_ld,
  input  logic [CELL_W-1:0] data_d,
  input  logic              start,
  input  logic              store,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CELL_W-1:0] data_q
);
  localparam int DEPTH = 1 << ADDR_W;

  typedef enum logic [1:0] {S_IDLE, S_DEC, S_XFER, S_FIN} st_t;

  st_t               st;
  logic              op_wr;
  logic [ADDR_W-1:0] hold_addr;
  logic [CELL_W-1:0] hold_data;
  logic [ADDR_W-1:0] row;
  logic [CELL_W-1:0] cells [DEPTH];

  logic idle;
  logic wr_en;

  assign idle   = (st == S_IDLE);
  assign wr_en  = (st == S_XFER) && op_wr;
  assign busy   = !idle;
  assign done   = (st == S_FIN);
  assign addr_q = hold_addr;
  assign data_q = hold_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      op_wr     <= 1'b0;
      hold_addr <= '0;
      hold_data <= '0;
      row       <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (addr_ld) hold_addr <= addr_d;
          if (data_ld) hold_data <= data_d;
          if (start) begin
            op_wr <= store;
            st    <= S_DEC;
          end
        end
        S_DEC: begin
          row <= hold_addr;
          st  <= S_XFER;
        end
        S_XFER: begin
          if (!op_wr) hold_data <= cells[row];
          st <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) cells[row] <= hold_data;
  end
endmodule

module staged_ram_ctrl_chk #(
  parameter int CELL_W = 8,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] addr_q,
  input logic [CELL_W-1:0] data_q
);
  p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_addr_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(addr_q));

  p_data_moves_at_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (done || $stable(data_q)));

  p_fixed_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> !done ##1 done);

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  p_done_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
endmodule

bind staged_ram_ctrl staged_ram_ctrl_chk #(.CELL_W(CELL_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .addr_q(addr_q), .data_q(data_q)
);

// File: tb/staged_ram_ctrl_bench.sv
`timescale 1ns/1ps
module staged_ram_ctrl_bench;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int NV = 12;

  // {store, addr, preload data, expected data_q at done}
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 8'h00, 8'hA5, 8'hA5},
    {1'b1, 8'hFF, 8'h3C, 8'h3C},
    {1'b1, 8'h10, 8'hFF, 8'hFF},
    {1'b1, 8'h11, 8'h00, 8'h00},
    {1'b0, 8'h00, 8'h77, 8'hA5},
    {1'b0, 8'hFF, 8'h00, 8'h3C},
    {1'b0, 8'h10, 8'h12, 8'hFF},
    {1'b0, 8'h11, 8'hEE, 8'h00},
    {1'b1, 8'h10, 8'h5A, 8'h5A},
    {1'b0, 8'h10, 8'h01, 8'h5A},
    {1'b0, 8'h11, 8'h81, 8'h00},
    {1'b0, 8'h00, 8'h42, 8'hA5}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_ld = 1'b0, data_ld = 1'b0, start = 1'b0, store = 1'b0;
  logic [AW-1:0] addr_d = '0;
  logic [DW-1:0] data_d = '0;
  logic busy, done;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  int nchk = 0;
  int nerr = 0;
  int cyc = 0;
  bit fin = 1'b0;

  always #2.5 clk = ~clk;

  staged_ram_ctrl #(.CELL_W(DW), .ADDR_W(AW)) u_staged_ram_ctrl (
    .clk(clk), .rst_n(rst_n), .addr_ld(addr_ld), .addr_d(addr_d),
    .data_ld(data_ld), .data_d(data_d), .start(start), .store(store),
    .busy(busy), .done(done), .addr_q(addr_q), .data_q(data_q)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic op, input logic [7:0] a, input logic [7:0] d, output int lat);
    @(negedge clk);
    addr_ld = 1'b1; addr_d = a; data_ld = 1'b1; data_d = d;
    @(negedge clk);
    addr_ld = 1'b0; data_ld = 1'b0; store = op; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !fin) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0d expected=<20000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 addr", addr_q, 0);
    check("R1 data", data_q, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 data after release", data_q, 0);

    // R2 load visibility on idle cycle
    addr_ld = 1'b1; addr_d = 8'h5C; data_ld = 1'b1; data_d = 8'hC3;
    @(negedge clk);
    addr_ld = 1'b0; data_ld = 1'b0;
    check("R2 addr load", addr_q, 8'h5C);
    check("R2 data load", data_q, 8'hC3);

    // table walk: R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][24], VEC[i][23:16], VEC[i][15:8], lat);
      check("R4 latency", lat, 3);
      check(VEC[i][24] ? "R6 write data kept" : "R5 read data", data_q, VEC[i][7:0]);
      check("R7 addr kept", addr_q, VEC[i][23:16]);
      @(negedge clk);
      check("R4 done single cycle", {done, busy}, 2'b00);
      check("R7 data kept", data_q, VEC[i][7:0]);
    end

    // R3 and R2: start and loads held during busy are ignored
    @(negedge clk);
    addr_ld = 1'b1; addr_d = 8'h40; data_ld = 1'b1; data_d = 8'h66;
    @(negedge clk);
    addr_ld = 1'b0; data_ld = 1'b0; store = 1'b1; start = 1'b1;
    @(negedge clk);
    check("R3 busy after accept", busy, 1);
    addr_ld = 1'b1; addr_d = 8'h41; data_ld = 1'b1; data_d = 8'h99; store = 1'b0;
    @(negedge clk);
    check("R3 still busy", {busy, done}, 2'b10);
    @(negedge clk);
    check("R4 done in third cycle", done, 1);
    start = 1'b0; addr_ld = 1'b0; data_ld = 1'b0;
    check("R2 addr load ignored while busy", addr_q, 8'h40);
    check("R2 data load ignored while busy", data_q, 8'h66);
    lat = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (done || busy) lat++;
    end
    check("R3 held start gave no second op", lat, 0);
    run_op(1'b0, 8'h40, 8'h00, lat);
    check("R6 write landed, held direction ignored", data_q, 8'h66);
    run_op(1'b0, 8'h10, 8'h00, lat);
    check("R6 other cell untouched", data_q, 8'h5A);

    // R1 reset in the middle of an operation
    @(negedge clk);
    store = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-op busy", {busy, done}, 2'b00);
    check("R1 mid-op addr", addr_q, 0);
    check("R1 mid-op data", data_q, 0);
    rst_n = 1'b1;
    run_op(1'b0, 8'hFF, 8'h00, lat);
    check("R8 top address after reset", data_q, 8'h3C);

    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule